// File: doc/BRIEF.md
# Dynamic-Bound Dead Zone Unit

This block removes a band of small values from a stream of signed fixed-point samples. The edges of the band are not fixed at build time. A lower edge and an upper edge arrive on their own ports next to every sample, so the band can move from one cycle to the next.

For each sample marked valid, the block compares the sample against both edges. A sample inside the band, edges included, gives a result of zero. A sample above the band gives the distance above the upper edge. A sample below the band gives the negative distance below the lower edge.

The result is one bit wider than the operands, so the subtraction never wraps. Two parameters set how many register stages sit before and after the arithmetic. A valid flag travels through the same stages as the data, so the result and its flag always leave together.

Top module: `dz_dyn_band`

## Requirements
- R1: When lo_i <= x_i <= hi_i (both edges inclusive), the result for that sample is exactly zero.
- R2: When x_i > hi_i, the result equals x_i - hi_i and is positive.
- R3: When x_i < lo_i and x_i is not above hi_i, the result equals x_i - lo_i and is negative.
- R4: y_o is W+1 bits, two's complement. It holds the exact difference for any operands, including the extremes x_i = -2^(W-1) with lo_i = 2^(W-1)-1, and x_i = 2^(W-1)-1 with hi_i = -2^(W-1).
- R5: If lo_i > hi_i and the sample is above hi_i, the above-upper case (R2) takes priority over the below-lower case.
- R6: vld_o repeats vld_i exactly IN_STAGES+OUT_STAGES cycles later, and y_o in that cycle is the result for the sample that carried the flag.
- R7: While rst is high at a rising edge, every pipeline valid bit is cleared and every output register is set to zero. In the next cycle vld_o is 0 and y_o is 0, and no stale valid appears after reset is released.
- R8: Both edges are taken from the ports in the same cycle as their sample. A back-to-back stream whose edges change every cycle gives, for every sample, the result for its own edges.
- R9: With IN_STAGES = 0 and OUT_STAGES = 0, y_o and vld_o follow the inputs combinationally, with no clock edge between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| vld_i | input | 1 | Sample valid |
| x_i | input | W | Signed sample |
| lo_i | input | W | Signed lower band edge for this sample |
| hi_i | input | W | Signed upper band edge for this sample |
| vld_o | output | 1 | Result valid, delayed by IN_STAGES+OUT_STAGES |
| y_o | output | W+1 | Signed result |

## Verification
Each fault inside this block shows at the ports as soon as the affected sample leaves the pipeline, that is IN_STAGES+OUT_STAGES cycles after it enters.
- An edge register that drifts out of step with the data register gives a wrong result in a stream where the edges change every cycle.
- A wrong compare or a wrong subtraction shows as a wrong value at the band edges or at the operand extremes.
- A valid bit that is delayed too much, delayed too little, or not cleared by reset shows as vld_o rising in the wrong cycle.
- A result that is not widened enough shows as a wrong sign at the extremes.

// File: rtl/dz_dyn_band.sv
module dz_dyn_band #(
  parameter int W          = 12,
  parameter int IN_STAGES  = 1,
  parameter int OUT_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                vld_i,
  input  logic signed [W-1:0] x_i,
  input  logic signed [W-1:0] lo_i,
  input  logic signed [W-1:0] hi_i,
  output logic                vld_o,
  output logic signed [W:0]   y_o
);

  logic signed [W-1:0] xc, lc, hc;
  logic                vc;
  logic signed [W:0]   core;
  logic                above, below;

  generate
    if (IN_STAGES == 0) begin : g_in_none
      assign xc = x_i;
      assign lc = lo_i;
      assign hc = hi_i;
      assign vc = vld_i;
    end else begin : g_in_regs
      logic signed [W-1:0] xr [IN_STAGES];
      logic signed [W-1:0] lr [IN_STAGES];
      logic signed [W-1:0] hr [IN_STAGES];
      logic [IN_STAGES-1:0] vr;
      always_ff @(posedge clk) begin
        xr[0] <= x_i;
        lr[0] <= lo_i;
        hr[0] <= hi_i;
        for (int i = 1; i < IN_STAGES; i++) begin
          xr[i] <= xr[i-1];
          lr[i] <= lr[i-1];
          hr[i] <= hr[i-1];
        end
        if (rst) vr <= '0;
        else     vr <= {vr, vld_i}; 
      end
      assign xc = xr[IN_STAGES-1];
      assign lc = lr[IN_STAGES-1];
      assign hc = hr[IN_STAGES-1];
      assign vc = vr[IN_STAGES-1];
    end
  endgenerate

  assign above = xc > hc;
  assign below = xc < lc;
  assign core  = above ? ($signed({xc[W-1], xc}) - $signed({hc[W-1], hc})) :
                 below ? ($signed({xc[W-1], xc}) - $signed({lc[W-1], lc})) :
                         '0;

  generate
    if (OUT_STAGES == 0) begin : g_out_none
      assign y_o   = core;
      assign vld_o = vc;
    end else begin : g_out_regs
      logic signed [W:0]     yr [OUT_STAGES];
      logic [OUT_STAGES-1:0] vr;
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < OUT_STAGES; i++) yr[i] <= '0;
          vr <= '0;
        end else begin
          yr[0] <= core;
          for (int i = 1; i < OUT_STAGES; i++) yr[i] <= yr[i-1];
          vr <= {vr, vc};
        end
      end
      assign y_o   = yr[OUT_STAGES-1];
      assign vld_o = vr[OUT_STAGES-1];

      a_r7_reset_clears: assert property (@(posedge clk)
        $past(rst) |-> (!vld_o && y_o == '0));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst && vc) begin
      if (!above && !below)
        a_r1_band_zero: assert (core == '0);
      if (above)
        a_r2_above_positive: assert (core > 0 && !core[W]);
      if (below && !above)
        a_r3_below_negative: assert (core < 0 && core[W]);
      if (above && below)
        a_r5_upper_wins: assert (core == $signed({xc[W-1], xc}) - $signed({hc[W-1], hc}));
    end
  end

endmodule

// File: tb/sim_dz_dyn_band.sv
module sim_dz_dyn_band;
  localparam int P   = 10;
  localparam int W   = 12;
  localparam int INS = 1;
  localparam int OUTS = 2;
  localparam int LAT = INS + OUTS;
  localparam int MAXV = (1 << (W-1)) - 1;
  localparam int MINV = -(1 << (W-1));

  logic clk = 0, rst = 1, vld = 0;
  logic signed [W-1:0] x = '0, lo = '0, hi = '0;
  logic v0, v1;
  logic signed [W:0] y0, y1;
  int nchk = 0, nfail = 0;

  always #(P/2) clk = ~clk;

  dz_dyn_band #(.W(W), .IN_STAGES(INS), .OUT_STAGES(OUTS)) u0 (
    .clk(clk), .rst(rst), .vld_i(vld), .x_i(x), .lo_i(lo), .hi_i(hi),
    .vld_o(v0), .y_o(y0));

  dz_dyn_band #(.W(W), .IN_STAGES(0), .OUT_STAGES(0)) u1 (
    .clk(clk), .rst(rst), .vld_i(vld), .x_i(x), .lo_i(lo), .hi_i(hi),
    .vld_o(v1), .y_o(y1));

  function automatic int ref_dz(int a, int l, int h);
    if (a > h) return a - h;
    if (a < l) return a - l;
    return 0;
  endfunction

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic run_one(string req, int a, int l, int h);
    @(negedge clk);
    x = a[W-1:0]; lo = l[W-1:0]; hi = h[W-1:0]; vld = 1;
    #1;
    chk({req, " R9 comb"}, int'(y1), ref_dz(a, l, h));
    chk("R9 comb valid", int'(v1), 1);
    @(negedge clk);
    vld = 0;
    chk("R6 valid not early", int'(v0), 0);
    repeat (LAT-1) @(negedge clk);
    chk({req, " valid"}, int'(v0), 1);
    chk(req, int'(y0), ref_dz(a, l, h));
    @(negedge clk);
    chk("R6 valid single", int'(v0), 0);
  endtask

  task automatic t_stream();
    int xs[8] = '{5, -5, 0, 100, -100, 7, -2048, 2047};
    int ls[8] = '{-3, -3, 1, 50, -50, 7, 10, -10};
    int hs[8] = '{3, 3, 4, 60, -60, 6, 20, 0};
    for (int k = 0; k < 8 + LAT; k++) begin
      @(negedge clk);
      if (k >= LAT) begin
        chk("R8 stream valid", int'(v0), 1);
        chk("R8 stream value", int'(y0), ref_dz(xs[k-LAT], ls[k-LAT], hs[k-LAT]));
      end
      if (k < 8) begin
        x = xs[k][W-1:0]; lo = ls[k][W-1:0]; hi = hs[k][W-1:0]; vld = 1;
      end else vld = 0;
    end
    @(negedge clk);
    chk("R6 stream end", int'(v0), 0);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    x = 12'sd300; lo = -12'sd1; hi = 12'sd1; vld = 1;
    repeat (LAT) @(negedge clk);
    chk("R7 pre valid", int'(v0), 1);
    rst = 1;
    @(negedge clk);
    chk("R7 valid cleared", int'(v0), 0);
    chk("R7 output zero", int'(y0), 0);
    rst = 0; vld = 0;
    for (int k = 0; k <= LAT; k++) begin
      @(negedge clk);
      chk("R7 no stale valid", int'(v0), 0);
    end
  endtask

  initial begin
    #(P*200000);
    nfail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R7 reset valid", int'(v0), 0);
    chk("R7 reset output", int'(y0), 0);
    rst = 0;
    run_one("R1 inside", 2, -4, 9);
    run_one("R1 at lower edge", -4, -4, 9);
    run_one("R1 at upper edge", 9, -4, 9);
    run_one("R2 above", 25, -4, 9);
    run_one("R2 above by one", 10, -4, 9);
    run_one("R3 below", -30, -4, 9);
    run_one("R3 below by one", -5, -4, 9);
    run_one("R4 low extreme", MINV, MAXV, MAXV);
    run_one("R4 high extreme", MAXV, MINV, MINV);
    run_one("R5 inverted band upper wins", 8, 10, 5);
    run_one("R5 inverted band below", 3, 10, 5);
    t_stream();
    t_reset_mid();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule